// File: doc/BRIEF.md
# Debounced Overhead Field Register

This block filters a field that repeats in a framed bit stream, such as one overhead bit, a small group of bits or a full byte, before the field reaches a status register. Each time the field occurs, an upstream extractor presents it together with a one-cycle occurrence strobe. The block keeps a stored value and changes it only after a new value has arrived on several occurrences in a row. A single corrupted occurrence therefore never reaches the status register.

The block also watches for a field that will not settle. It raises an unstable flag when occurrence after occurrence brings a value that matches neither the stored value nor the sample just before it. It clears the flag once the field has settled again. A one-cycle pulse marks each cycle in which a different value is committed to the stored register. The width of the field and the three run lengths are parameters.

Top module: `integ_value_reg`

## Requirements
- R1: While the active-low reset is asserted, the stored value is 0 and the change pulse and the unstable flag are low. A run of samples cut short by reset counts for nothing afterwards.
- R2: On a cycle with the occurrence strobe low, the stored value, the unstable flag and all internal counts keep their values, and the change pulse is low.
- R3: A value that differs from the stored value is committed on the fifth consecutive occurrence that carries it (STORE_RUN = 5). The stored value output shows the new value in the cycle after the edge that sampled that fifth occurrence.
- R4: An occurrence whose sample differs from the previous occurrence's sample restarts the run count at one. A run of four, a different sample, and then four more of the first value does not commit.
- R5: Further occurrences of a value that is already stored do not commit it again and do not pulse the change output.
- R6: The change pulse is high for exactly the one cycle in which the stored value output first shows a newly committed value.
- R7: The unstable flag rises after the eighth consecutive occurrence whose sample equals neither the stored value nor the previous occurrence's sample (UNSTABLE_RUN = 8). After seven such occurrences it is still low.
- R8: An occurrence whose sample equals the stored value or the previous sample resets the mismatch count to zero. The count then needs eight fresh mismatching occurrences before the flag rises.
- R9: The unstable flag clears on the fifth consecutive occurrence of one value (CLEAR_RUN = 5), whether or not that value differs from the stored value and is committed.
- R10: The field width W is a parameter. With W = 1, a single bit is filtered under the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| occ_i | input | 1 | Occurrence strobe: field_i is valid this cycle |
| field_i | input | W | Sampled field value |
| value_o | output | W | Integrated (stored) field value |
| change_o | output | 1 | One-cycle pulse when a different value is committed |
| unstable_o | output | 1 | Field has been failing to settle |

## Verification
A clean run of five repeats separates a commit on the fifth occurrence from one on the fourth or sixth. A run of four broken by a single other value shows whether the run count really restarts. Idle cycles in the middle of a run show that only strobed cycles count. For the unstable flag, a strictly changing sequence of eight samples separates a threshold of seven from one of eight. A repeat of the previous sample, and separately a sample equal to the stored value, each placed after seven mismatches, show that both kinds of match reset the mismatch count. A settle run on the value already stored tells apart clearing the flag from committing a value.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

   // Saturating increment used by all occurrence counters.
   function automatic int unsigned sat_step(input int unsigned cur, input int unsigned lim);
      return (cur >= lim) ? lim : cur + 1;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ivr_repeat_cnt.sv
// Tracks the previous sample and how many consecutive occurrences carried it.
module ivr_repeat_cnt #(
   parameter int W       = 8,
   parameter int RUN_MAX = 5,
   localparam int CW     = $clog2(RUN_MAX + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          occ_i,
   input  logic [W-1:0]  field_i,
   output logic          same_o,
   output logic [CW-1:0] run_next_o
);
   import ivr_pkg::*;

   logic [W-1:0]  prev_q;
   logic [CW-1:0] run_q;

   assign same_o     = (field_i == prev_q);
   assign run_next_o = same_o ? CW'(sat_step(int'(run_q), RUN_MAX)) : CW'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= '0;
         run_q  <= '0;
      end else if (occ_i) begin
         prev_q <= field_i;
         run_q  <= run_next_o;
      end
   end
endmodule

// File: rtl/ivr_mismatch_cnt.sv
// Counts consecutive occurrences that match neither reference.
module ivr_mismatch_cnt #(
   parameter int LIMIT = 8,
   localparam int MW   = $clog2(LIMIT + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic occ_i,
   input  logic hit_i,
   output logic reach_o
);
   import ivr_pkg::*;

   localparam logic [MW-1:0] LIM_V = MW'(LIMIT);

   logic [MW-1:0] cnt_q;
   logic [MW-1:0] cnt_next;

   assign cnt_next = hit_i ? '0 : MW'(sat_step(int'(cnt_q), LIMIT));
   assign reach_o  = occ_i && (cnt_next >= LIM_V);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (occ_i) cnt_q <= cnt_next;
   end
endmodule

// File: rtl/integ_value_reg.sv
module integ_value_reg #(
   parameter int W            = 8,
   parameter int STORE_RUN    = 5,
   parameter int UNSTABLE_RUN = 8,
   parameter int CLEAR_RUN    = 5
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         occ_i,
   input  logic [W-1:0] field_i,
   output logic [W-1:0] value_o,
   output logic         change_o,
   output logic         unstable_o
);
   import ivr_pkg::*;

   localparam int RUN_MAX = int'(max2(STORE_RUN, CLEAR_RUN));
   localparam int RCW     = $clog2(RUN_MAX + 1);
   localparam logic [RCW-1:0] STORE_V = RCW'(STORE_RUN);
   localparam logic [RCW-1:0] CLEAR_V = RCW'(CLEAR_RUN);

   // Elaboration-time parameter checks
   if (W < 1)            begin : g_bad_w     $error("W must be at least 1"); end
   if (STORE_RUN < 1)    begin : g_bad_store $error("STORE_RUN must be at least 1"); end
   if (UNSTABLE_RUN < 1) begin : g_bad_unst  $error("UNSTABLE_RUN must be at least 1"); end
   if (CLEAR_RUN < 1)    begin : g_bad_clear $error("CLEAR_RUN must be at least 1"); end

   logic [W-1:0]   value_q;
   logic           change_q;
   logic           unstable_q;
   logic           same_prev;
   logic           same_stored;
   logic [RCW-1:0] run_next;
   logic           unst_reach;
   logic           commit;

   ivr_repeat_cnt #(.W(W), .RUN_MAX(RUN_MAX)) u_repeat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .occ_i      (occ_i),
      .field_i    (field_i),
      .same_o     (same_prev),
      .run_next_o (run_next)
   );

   // Comparison against the stored value: bit form or vector form
   if (W == 1) begin : g_cmp_bit
      assign same_stored = ~(field_i[0] ^ value_q[0]);
   end else begin : g_cmp_vec
      assign same_stored = (field_i == value_q);
   end

   ivr_mismatch_cnt #(.LIMIT(UNSTABLE_RUN)) u_mismatch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .occ_i   (occ_i),
      .hit_i   (same_prev || same_stored),
      .reach_o (unst_reach)
   );

   assign commit = occ_i && (run_next >= STORE_V) && !same_stored;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         value_q    <= '0;
         change_q   <= 1'b0;
         unstable_q <= 1'b0;
      end else begin
         change_q <= commit;
         if (commit) value_q <= field_i;
         if (unst_reach)                       unstable_q <= 1'b1;
         else if (occ_i && run_next >= CLEAR_V) unstable_q <= 1'b0;
      end
   end

   assign value_o    = value_q;
   assign change_o   = change_q;
   assign unstable_o = unstable_q;
endmodule

// File: rtl/ivr_checker.sv
module ivr_checker #(
   parameter int W = 8
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         occ_i,
   input logic [W-1:0] field_i,
   input logic [W-1:0] value_o,
   input logic         change_o,
   input logic         unstable_o
);
   // R2
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !occ_i |=> $stable(value_o) && $stable(unstable_o) && !change_o);

   // R3
   value_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(value_o) |-> $past(occ_i) && (value_o == $past(field_i)));

   // R6
   pulse_marks_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      change_o |-> (value_o != $past(value_o)));

   // R6
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      change_o |=> !change_o);

   // R7
   unstable_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(unstable_o) |-> $past(occ_i));

   // R9
   unstable_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(unstable_o) |-> $past(occ_i) && (field_i != '0 || field_i == '0));
endmodule

bind integ_value_reg ivr_checker #(.W(W)) u_ivr_checker (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .occ_i      (occ_i),
   .field_i    (field_i),
   .value_o    (value_o),
   .change_o   (change_o),
   .unstable_o (unstable_o)
);

// File: tb/test_integ_value_reg.sv
`timescale 1ns/1ps
module test_integ_value_reg;
   localparam real HALF = 2.5;

   typedef struct packed {
      logic       occ;
      logic [7:0] smp;
      logic [7:0] val;
      logic       chg;
      logic       uns;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 61;
   // req column gives the requirement number the row checks (R2..R9)
   localparam vec_t VEC [NV] = '{
      '{1'b1,8'h00,8'h00,1'b0,1'b0,4'd3},
      '{1'b1,8'hA5,8'h00,1'b0,1'b0,4'd3},
      '{1'b1,8'hA5,8'h00,1'b0,1'b0,4'd3},
      '{1'b1,8'hA5,8'h00,1'b0,1'b0,4'd3},
      '{1'b1,8'hA5,8'h00,1'b0,1'b0,4'd3},
      '{1'b1,8'hA5,8'hA5,1'b1,1'b0,4'd3},   // R3 fifth repeat commits, R6 pulse
      '{1'b0,8'h3C,8'hA5,1'b0,1'b0,4'd2},   // R2 idle
      '{1'b1,8'hA5,8'hA5,1'b0,1'b0,4'd5},   // R5 no re-commit
      '{1'b1,8'h01,8'hA5,1'b0,1'b0,4'd7},
      '{1'b1,8'h02,8'hA5,1'b0,1'b0,4'd7},
      '{1'b1,8'h03,8'hA5,1'b0,1'b0,4'd7},
      '{1'b0,8'h04,8'hA5,1'b0,1'b0,4'd2},   // R2 idle inside mismatch run
      '{1'b1,8'h04,8'hA5,1'b0,1'b0,4'd7},
      '{1'b1,8'h05,8'hA5,1'b0,1'b0,4'd7},
      '{1'b1,8'h06,8'hA5,1'b0,1'b0,4'd7},
      '{1'b1,8'h07,8'hA5,1'b0,1'b0,4'd7},   // R7 seven: still low
      '{1'b1,8'h08,8'hA5,1'b0,1'b1,4'd7},   // R7 eighth: raised
      '{1'b1,8'h11,8'hA5,1'b0,1'b1,4'd9},
      '{1'b1,8'h11,8'hA5,1'b0,1'b1,4'd9},
      '{1'b1,8'h11,8'hA5,1'b0,1'b1,4'd9},
      '{1'b1,8'h11,8'hA5,1'b0,1'b1,4'd9},
      '{1'b1,8'h11,8'h11,1'b1,1'b0,4'd9},   // R9 clear with commit
      '{1'b1,8'h44,8'h11,1'b0,1'b0,4'd4},
      '{1'b1,8'h44,8'h11,1'b0,1'b0,4'd4},
      '{1'b1,8'h44,8'h11,1'b0,1'b0,4'd4},
      '{1'b1,8'h44,8'h11,1'b0,1'b0,4'd4},
      '{1'b1,8'h45,8'h11,1'b0,1'b0,4'd4},   // R4 break
      '{1'b1,8'h44,8'h11,1'b0,1'b0,4'd4},
      '{1'b1,8'h44,8'h11,1'b0,1'b0,4'd4},
      '{1'b1,8'h44,8'h11,1'b0,1'b0,4'd4},
      '{1'b1,8'h44,8'h11,1'b0,1'b0,4'd4},   // R4 four after break: no commit
      '{1'b1,8'h44,8'h44,1'b1,1'b0,4'd4},
      '{1'b1,8'h20,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h21,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h22,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h23,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h24,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h25,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h26,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h26,8'h44,1'b0,1'b0,4'd8},   // R8 equal previous resets count
      '{1'b1,8'h30,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h31,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h32,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h33,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h34,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h35,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h36,8'h44,1'b0,1'b0,4'd8},
      '{1'b1,8'h37,8'h44,1'b0,1'b1,4'd7},
      '{1'b1,8'h44,8'h44,1'b0,1'b1,4'd8},   // R8 equal stored resets count
      '{1'b1,8'h50,8'h44,1'b0,1'b1,4'd8},
      '{1'b1,8'h51,8'h44,1'b0,1'b1,4'd8},
      '{1'b1,8'h52,8'h44,1'b0,1'b1,4'd8},
      '{1'b1,8'h53,8'h44,1'b0,1'b1,4'd8},
      '{1'b1,8'h54,8'h44,1'b0,1'b1,4'd8},
      '{1'b1,8'h55,8'h44,1'b0,1'b1,4'd8},
      '{1'b1,8'h56,8'h44,1'b0,1'b1,4'd8},
      '{1'b1,8'h44,8'h44,1'b0,1'b1,4'd9},
      '{1'b1,8'h44,8'h44,1'b0,1'b1,4'd9},
      '{1'b1,8'h44,8'h44,1'b0,1'b1,4'd9},
      '{1'b1,8'h44,8'h44,1'b0,1'b1,4'd9},
      '{1'b1,8'h44,8'h44,1'b0,1'b0,4'd9}    // R9 clear without commit
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       occ = 1'b0;
   logic [7:0] field = 8'h00;
   logic [7:0] value;
   logic       change;
   logic       unstable;
   logic       b_occ = 1'b0;
   logic [0:0] b_field = 1'b0;
   logic [0:0] b_value;
   logic       b_change;
   logic       b_unstable;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(HALF) clk = ~clk;

   integ_value_reg #(.W(8)) i_integ_value_reg (
      .clk_i(clk), .rst_ni(rst_n), .occ_i(occ), .field_i(field),
      .value_o(value), .change_o(change), .unstable_o(unstable));

   integ_value_reg #(.W(1)) i_integ_value_reg_bit (
      .clk_i(clk), .rst_ni(rst_n), .occ_i(b_occ), .field_i(b_field),
      .value_o(b_value), .change_o(b_change), .unstable_o(b_unstable));

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic o, input logic [7:0] s);
      @(negedge clk);
      occ   = o;
      field = s;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(HALF * 2 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "value in reset", int'(value), 0);
      check("R1", "change in reset", int'(change), 0);
      check("R1", "unstable in reset", int'(unstable), 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i].occ, VEC[i].smp);
         check($sformatf("R%0d", VEC[i].req), $sformatf("row %0d value", i), int'(value), int'(VEC[i].val));
         check($sformatf("R%0d", VEC[i].req), $sformatf("row %0d change", i), int'(change), int'(VEC[i].chg));
         check($sformatf("R%0d", VEC[i].req), $sformatf("row %0d unstable", i), int'(unstable), int'(VEC[i].uns));
      end
      step(1'b0, 8'h00);

      // R1 reset in the middle of a run
      step(1'b1, 8'h77);
      step(1'b1, 8'h77);
      step(1'b1, 8'h77);
      @(negedge clk);
      rst_n = 1'b0;
      occ   = 1'b0;
      #1;
      check("R1", "value after mid-run reset", int'(value), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 8'h77);
      step(1'b1, 8'h77);
      check("R1", "run not carried over reset", int'(value), 0);
      step(1'b1, 8'h77);
      step(1'b1, 8'h77);
      check("R3", "fourth after reset", int'(value), 0);
      step(1'b1, 8'h77);
      check("R3", "fifth after reset commits", int'(value), 'h77);
      check("R6", "pulse on commit", int'(change), 1);
      step(1'b0, 8'h00);
      check("R6", "pulse one cycle", int'(change), 0);

      // R10 single-bit field
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); b_occ = 1'b1; b_field = 1'b1;
         @(posedge clk); #1;
      end
      check("R10", "bit after four", int'(b_value), 0);
      @(negedge clk); b_occ = 1'b1; b_field = 1'b1;
      @(posedge clk); #1;
      check("R10", "bit after five", int'(b_value), 1);
      check("R10", "bit pulse", int'(b_change), 1);
      @(negedge clk); b_occ = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule